// File: doc/BRIEF.md
# Indexed Colour Lookup Table Host Port

This block is the byte-wide host front end of a 256-entry colour lookup table, each entry holding 8-bit red, green and blue components. The host selects an entry by writing a read index or a write index. It then moves one colour component per access to a shared data port, always in the order red, green, blue. After the blue component of an entry, the index steps to the next entry, so a whole palette can be streamed without rewriting the index.

A mode input points the same three ports at a separate two-colour cursor table. In that mode only bit 0 of the index selects the entry, and the index stays where it is after blue. A pixel-side port returns a full 24-bit colour from the main table, and a second pixel-side port does the same for the cursor table. Both are registered and never wait for host traffic.

Top module: `clut_host_port`

## Requirements
- R1: After reset both indices are 0, the component counter is at red, `host_rdata`, `pix_rgb` and `cur_pix_rgb` are 0, and every entry of both tables is 0.
- R2: A host write to address 1 loads the write index from `host_wdata` and returns the component counter to red. A host read of address 1 returns the write index on `host_rdata` one cycle after the strobe.
- R3: A host write to address 0 loads the read index and returns the component counter to red. A host read of address 0 returns the read index one cycle after the strobe.
- R4: Data-port (address 2) writes carry red, then green, then blue. Red and green are held in staging, and the entry becomes visible only when blue is written. A single component counter is shared by data reads and writes and cycles red, green, blue.
- R5: In main mode (`cursor_mode`=0), a blue data write stores {red,green,blue} at the write index and then increments the write index, wrapping from 255 to 0.
- R6: In main mode, data reads return red, green and blue of the entry at the read index, one cycle after each strobe. The read index increments after blue and wraps from 255 to 0.
- R7: With `cursor_mode`=1, a blue data write stores into cursor entry `wr_idx[0]`, leaves the main table unchanged, and leaves the write index unchanged.
- R8: With `cursor_mode`=1, data reads return components of cursor entry `rd_idx[0]`, and the read index does not change.
- R9: `pix_rgb` equals main entry `pix_idx` as {red[23:16],green[15:8],blue[7:0]} one cycle after `pix_idx` is presented, and `cur_pix_rgb` likewise equals cursor entry `cur_pix_sel`, whatever the host does. When an entry is committed in the same cycle as it is looked up, the pixel port shows the value from before the commit.
- R10: `host_rdata` changes only on a host read. Reads of address 3 return 0, and writes to address 3 change no state. A cycle with both strobes active is handled as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Port select: 0 read index, 1 write index, 2 data, 3 unused |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| cursor_mode | input | 1 | 1 redirects the ports to the cursor table |
| pix_idx | input | 8 | Pixel-side main table index |
| pix_rgb | output | 24 | Registered main table colour |
| cur_pix_sel | input | 1 | Pixel-side cursor entry select |
| cur_pix_rgb | output | 24 | Registered cursor table colour |

## Verification
The assertions assume the host never raises both strobes in the same cycle, and that `cursor_mode` is stable across any data access the checks look at. The write-wins rule is defined, but one of the checks names this exclusivity directly. The stimulus drives strobes from a single operation choice per cycle, so both are never set together. It changes the mode only between host operations. The counter and index checks then hold on every cycle outside reset.

// File: rtl/clut_pkg.sv
// Package: shared port codes and the component sequence type for the
// colour lookup table host port. Assumes a 2-bit host address.
package clut_pkg;

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;

    localparam logic [1:0] PORT_RIDX = 2'd0;
    localparam logic [1:0] PORT_WIDX = 2'd1;
    localparam logic [1:0] PORT_DATA = 2'd2;

    // Step to the next colour component, blue wraps back to red
    function automatic comp_e comp_next(input comp_e c);
        case (c)
            COMP_RED:   comp_next = COMP_GREEN;
            COMP_GREEN: comp_next = COMP_BLUE;
            default:    comp_next = COMP_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_access_seq.sv
// Module: index registers and the shared red/green/blue component counter.
// Decodes host strobes into data-port write/read events and a commit pulse.
// Assumes IDX_W <= CHAN_W; a write wins over a read in the same cycle.
module clut_access_seq
    import clut_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [CHAN_W-1:0] host_wdata,
    input  logic              cursor_mode,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  wr_idx,
    output comp_e             comp,
    output logic              data_we,
    output logic              commit
);

    logic data_re;

    // Decode data-port accesses; read only counts when no write is present
    always_comb begin
        data_we = host_wr && (host_addr == PORT_DATA);
        data_re = !host_wr && host_rd && (host_addr == PORT_DATA);
        commit  = data_we && (comp == COMP_BLUE);
    end

    // Index registers and component counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx <= '0;
            wr_idx <= '0;
            comp   <= COMP_RED;
        end else if (host_wr) begin
            case (host_addr)
                PORT_RIDX: begin
                    rd_idx <= host_wdata[IDX_W-1:0];
                    comp   <= COMP_RED;
                end
                PORT_WIDX: begin
                    wr_idx <= host_wdata[IDX_W-1:0];
                    comp   <= COMP_RED;
                end
                PORT_DATA: begin
                    comp <= comp_next(comp);
                    if (comp == COMP_BLUE && !cursor_mode)
                        wr_idx <= wr_idx + 1'b1;
                end
                default: ;
            endcase
        end else if (data_re) begin
            comp <= comp_next(comp);
            if (comp == COMP_BLUE && !cursor_mode)
                rd_idx <= rd_idx + 1'b1;
        end
    end

endmodule

// File: rtl/clut_stage.sv
// Module: staging register for red and green of the entry being written.
// Presents the full colour word for the commit in the blue-write cycle.
// Assumes the component counter is driven by clut_access_seq.
module clut_stage
    import clut_pkg::*;
#(
    parameter int CHAN_W = 8,
    localparam int RGB_W = 3 * CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  comp_e             comp,
    input  logic [CHAN_W-1:0] host_wdata,
    output logic [RGB_W-1:0]  commit_rgb
);

    logic [CHAN_W-1:0] red_q;
    logic [CHAN_W-1:0] green_q;

    // Capture red and green as they arrive on the data port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q   <= '0;
            green_q <= '0;
        end else if (data_we) begin
            if (comp == COMP_RED)   red_q   <= host_wdata;
            if (comp == COMP_GREEN) green_q <= host_wdata;
        end
    end

    // Blue comes straight from the bus in the commit cycle
    always_comb commit_rgb = {red_q, green_q, host_wdata};

endmodule

// File: rtl/clut_table.sv
// Module: colour table with one write port, a combinational host read port
// and a registered pixel read port that reads the value before a same-cycle write.
// Assumes ENTRIES == 2**IDX_W.
module clut_table #(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8,
    parameter int RGB_W   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [RGB_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [RGB_W-1:0] rdata,
    input  logic [IDX_W-1:0] pix_addr,
    output logic [RGB_W-1:0] pix_rgb
);

    logic [RGB_W-1:0] mem [ENTRIES];

    // Entry storage: cleared by reset, written on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Host-side lookup, registered by the caller
    always_comb rdata = mem[raddr];

    // Pixel-side lookup, one cycle, never stalled
    always_ff @(posedge clk) begin
        if (!rst_n) pix_rgb <= '0;
        else        pix_rgb <= mem[pix_addr];
    end

endmodule

// File: rtl/clut_host_port.sv
// Module: top of the indexed colour lookup table host port. Routes host
// accesses to the main table or, in cursor mode, to the two-entry cursor
// table, and registers host read data. Assumes single-strobe host cycles.
module clut_host_port
    import clut_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int IDX_W  = 8,
    localparam int RGB_W   = 3 * CHAN_W,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [CHAN_W-1:0] host_wdata,
    output logic [CHAN_W-1:0] host_rdata,
    input  logic              cursor_mode,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb,
    input  logic              cur_pix_sel,
    output logic [RGB_W-1:0]  cur_pix_rgb
);

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    comp_e            comp;
    logic             data_we;
    logic             commit;
    logic [RGB_W-1:0] commit_rgb;
    logic [RGB_W-1:0] main_rd;
    logic [RGB_W-1:0] cur_rd;
    logic [RGB_W-1:0] sel_rgb;
    logic [CHAN_W-1:0] sel_byte;
    logic             main_we;
    logic             cur_we;

    clut_access_seq #(.CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .cursor_mode(cursor_mode),
        .rd_idx     (rd_idx),
        .wr_idx     (wr_idx),
        .comp       (comp),
        .data_we    (data_we),
        .commit     (commit)
    );

    clut_stage #(.CHAN_W(CHAN_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we   (data_we),
        .comp      (comp),
        .host_wdata(host_wdata),
        .commit_rgb(commit_rgb)
    );

    // Steer the commit to exactly one table
    always_comb begin
        main_we = commit && !cursor_mode;
        cur_we  = commit &&  cursor_mode;
    end

    clut_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .RGB_W(RGB_W)) u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (main_we),
        .waddr   (wr_idx),
        .wdata   (commit_rgb),
        .raddr   (rd_idx),
        .rdata   (main_rd),
        .pix_addr(pix_idx),
        .pix_rgb (pix_rgb)
    );

    clut_table #(.ENTRIES(2), .IDX_W(1), .RGB_W(RGB_W)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cur_we),
        .waddr   (wr_idx[0]),
        .wdata   (commit_rgb),
        .raddr   (rd_idx[0]),
        .rdata   (cur_rd),
        .pix_addr(cur_pix_sel),
        .pix_rgb (cur_pix_rgb)
    );

    // Pick the table and the component addressed by a data read
    always_comb begin
        sel_rgb = cursor_mode ? cur_rd : main_rd;
        case (comp)
            COMP_RED:   sel_byte = sel_rgb[RGB_W-1 -: CHAN_W];
            COMP_GREEN: sel_byte = sel_rgb[2*CHAN_W-1 -: CHAN_W];
            default:    sel_byte = sel_rgb[CHAN_W-1:0];
        endcase
    end

    // Register host read data; hold it when no read is performed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd && !host_wr) begin
            case (host_addr)
                PORT_RIDX: host_rdata <= CHAN_W'(rd_idx);
                PORT_WIDX: host_rdata <= CHAN_W'(wr_idx);
                PORT_DATA: host_rdata <= sel_byte;
                default:   host_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/clut_host_port_chk.sv
// Module: property checker for clut_host_port, attached by bind.
// Assumes the host never raises both strobes in one cycle.
module clut_host_port_chk #(
    parameter int CHAN_W = 8,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [CHAN_W-1:0] host_wdata,
    input logic [CHAN_W-1:0] host_rdata,
    input logic              cursor_mode,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [1:0]        comp
);

    // R10
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));

    // R2
    idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd1) |=> (comp == 2'd0 && wr_idx == $past(host_wdata[IDX_W-1:0])));

    // R3
    ridx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd0) |=> (comp == 2'd0 && rd_idx == $past(host_wdata[IDX_W-1:0])));

    // R4
    comp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comp != 2'd3);

    // R5
    wr_autoinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2 && comp == 2'd2 && !cursor_mode)
        |=> wr_idx == IDX_W'($past(wr_idx) + 1'b1));

    // R7
    cursor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && host_addr == 2'd2 && cursor_mode)
        |=> ($stable(wr_idx) && $stable(rd_idx)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

endmodule

bind clut_host_port clut_host_port_chk #(.CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cursor_mode(cursor_mode),
    .rd_idx     (rd_idx),
    .wr_idx     (wr_idx),
    .comp       (comp)
);

// File: tb/clut_host_port_bench.sv
module clut_host_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        cursor_mode = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic        cur_pix_sel = 1'b0;
    logic [23:0] cur_pix_rgb;

    always #10 clk = ~clk;

    clut_host_port u_clut_host_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cursor_mode(cursor_mode), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
        .cur_pix_sel(cur_pix_sel), .cur_pix_rgb(cur_pix_rgb)
    );

    // behavioural reference state
    logic [23:0] m_pal [256];
    logic [23:0] m_cur [2];
    logic [7:0]  m_wi, m_ri, m_r, m_g, e_rd;
    int          m_comp;
    logic [23:0] e_pix, e_cpix;
    string       req = "R1";
    int          n_chk = 0;
    int          n_bad = 0;
    int          cycles = 0;

    task automatic check(input string what, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("host_rdata", {16'h0, host_rdata}, {16'h0, e_rd});
        check("pix_rgb", pix_rgb, e_pix);
        check("cur_pix_rgb", cur_pix_rgb, e_cpix);
    endtask

    // update the reference with the inputs applied for the coming edge
    task automatic model_step(input logic wr, input logic rd, input logic [1:0] a, input logic [7:0] d);
        logic [23:0] ent;
        e_pix  = m_pal[pix_idx];
        e_cpix = m_cur[cur_pix_sel];
        if (wr) begin
            if (a == 2'd0) begin m_ri = d; m_comp = 0; end
            else if (a == 2'd1) begin m_wi = d; m_comp = 0; end
            else if (a == 2'd2) begin
                if (m_comp == 0) m_r = d;
                else if (m_comp == 1) m_g = d;
                else begin
                    if (cursor_mode) m_cur[m_wi[0]] = {m_r, m_g, d};
                    else begin m_pal[m_wi] = {m_r, m_g, d}; m_wi = m_wi + 8'd1; end
                end
                m_comp = (m_comp + 1) % 3;
            end
        end else if (rd) begin
            if (a == 2'd0) e_rd = m_ri;
            else if (a == 2'd1) e_rd = m_wi;
            else if (a == 2'd3) e_rd = 8'h00;
            else begin
                ent = cursor_mode ? m_cur[m_ri[0]] : m_pal[m_ri];
                e_rd = 8'((ent >> (8 * (2 - m_comp))) & 24'hff);
                if (m_comp == 2 && !cursor_mode) m_ri = m_ri + 8'd1;
                m_comp = (m_comp + 1) % 3;
            end
        end
    endtask

    // one clock: drive at the falling edge, compare at the next falling edge
    task automatic cyc(input logic wr, input logic rd, input logic [1:0] a, input logic [7:0] d);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
        model_step(wr, rd, a, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_b(input logic [1:0] a, input logic [7:0] d); cyc(1'b1, 1'b0, a, d); endtask
    task automatic rd_b(input logic [1:0] a); cyc(1'b0, 1'b1, a, 8'h00); endtask
    task automatic idle(); cyc(1'b0, 1'b0, 2'd0, 8'h00); endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_pal[i] = '0;
        m_cur[0] = '0; m_cur[1] = '0;
        m_wi = 0; m_ri = 0; m_r = 0; m_g = 0; e_rd = 0; m_comp = 0;
        e_pix = 0; e_cpix = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values at the ports, then indices read back as zero
        req = "R1";
        compare_all();
        rd_b(2'd1); rd_b(2'd0);
        for (int i = 0; i < 8; i++) begin pix_idx = 8'(i * 37); idle(); end

        // R2: write index load, readback, and counter restart mid-entry
        req = "R2";
        wr_b(2'd1, 8'h10); rd_b(2'd1);
        wr_b(2'd2, 8'hEE);
        wr_b(2'd1, 8'h10);
        wr_b(2'd2, 8'h01); wr_b(2'd2, 8'h02); wr_b(2'd2, 8'h03);
        pix_idx = 8'h10; idle(); idle();

        // R3: read index load and readback
        req = "R3";
        wr_b(2'd0, 8'h20); rd_b(2'd0);
        rd_b(2'd2); wr_b(2'd0, 8'h10); rd_b(2'd2); rd_b(2'd2); rd_b(2'd2);

        // R4: commit only on blue, visible through pixel port
        req = "R4";
        pix_idx = 8'h05;
        wr_b(2'd1, 8'h05);
        wr_b(2'd2, 8'h11); wr_b(2'd2, 8'h22); wr_b(2'd2, 8'h33);
        idle(); idle();

        // R5: auto-increment and wrap of write index
        req = "R5";
        wr_b(2'd1, 8'hFF);
        for (int i = 0; i < 6; i++) wr_b(2'd2, 8'(8'hA0 + i));
        rd_b(2'd1);
        pix_idx = 8'hFF; idle(); pix_idx = 8'h00; idle(); idle();

        // R6: streaming reads with read index wrap
        req = "R6";
        wr_b(2'd0, 8'hFE);
        for (int i = 0; i < 9; i++) rd_b(2'd2);
        rd_b(2'd0);

        // R7: cursor writes, no increment, main table untouched
        req = "R7";
        cursor_mode = 1'b1; idle();
        wr_b(2'd1, 8'h03);
        for (int i = 0; i < 6; i++) wr_b(2'd2, 8'(8'h50 + i));
        rd_b(2'd1);
        wr_b(2'd1, 8'h04);
        wr_b(2'd2, 8'h77); wr_b(2'd2, 8'h88); wr_b(2'd2, 8'h99);
        pix_idx = 8'h03; cur_pix_sel = 1'b1; idle();
        pix_idx = 8'h04; cur_pix_sel = 1'b0; idle(); idle();

        // R8: cursor reads, read index stays
        req = "R8";
        wr_b(2'd0, 8'h02);
        for (int i = 0; i < 6; i++) rd_b(2'd2);
        rd_b(2'd0);
        wr_b(2'd0, 8'h01);
        for (int i = 0; i < 3; i++) rd_b(2'd2);
        cursor_mode = 1'b0; idle();

        // R9: pixel lookups under random host traffic, same-cycle commits
        req = "R9";
        pix_idx = 8'h40;
        wr_b(2'd1, 8'h40);
        wr_b(2'd2, 8'h0A); wr_b(2'd2, 8'h0B); wr_b(2'd2, 8'h0C);
        idle();
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom_range(0, 2));
            pix_idx = 8'($urandom_range(0, 255));
            cur_pix_sel = 1'($urandom_range(0, 1));
            if (i % 50 == 0) begin cursor_mode = 1'($urandom_range(0, 1)); idle(); end
            else if (op == 0) idle();
            else if (op == 1) wr_b(2'($urandom_range(0, 3)), 8'($urandom));
            else rd_b(2'($urandom_range(0, 3)));
        end
        cursor_mode = 1'b0; idle();

        // R10: hold without reads, address 3 ignored and reads zero
        req = "R10";
        rd_b(2'd1);
        wr_b(2'd3, 8'h5A);
        for (int i = 0; i < 4; i++) begin pix_idx = 8'(i); idle(); end
        rd_b(2'd1); rd_b(2'd0); rd_b(2'd3); idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule